// File: doc/BRIEF.md
# Reloading Countdown Timer Channel

This block is one channel of a programmable countdown timer. Software reaches it through a small register-write/read interface: a reload value, a read-only current count, a control word, and a write-only acknowledge location. While enabled, the counter steps down by one on each pulse of the tick strobe chosen by the control word. The tick strobes are single-cycle enables that come from outside the block. One strobe is the fast reference and the other is a slower alternative.

When the count is zero and a tick arrives, the channel underflows. In periodic mode it reloads from the reload register, so a reload value of N−1 gives a period of N ticks. In free-running mode it wraps to all ones. Every underflow sets a sticky interrupt, which stays high until software writes to the acknowledge location. The counter width is a parameter, so one module serves both 16-bit and 32-bit channels.

The usual bring-up sequence has three steps. Software first writes the mode with the enable bit clear (0x48). It then writes the reload value, and finally sets the enable bit (0xC8).

Top module: `reload_timer`

## Requirements
- R1: After reset the reload register, the count, the control word and `irq` all read as zero.
- R2: Register offsets on `bus_addr` are 0 = reload value (read/write, CNT_W bits), 1 = current count (read-only; writes are ignored), 2 = control, 3 = acknowledge (reads zero). Control bit 7 is enable, bit 6 is periodic mode and bit 3 is fast-tick select. The other control bits read as zero.
- R3: A control write that sets bit 7 while the channel is disabled loads the count from the reload register. The new count is visible on the next cycle.
- R4: While enabled, each selected tick lowers a nonzero count by exactly one. While disabled, ticks leave the count unchanged.
- R5: With control bit 3 set, only `tick_fast` advances the count. With bit 3 clear, only `tick_slow` advances it.
- R6: In periodic mode, a tick at count zero reloads the reload value, which gives a period of reload+1 ticks.
- R7: In free-running mode, a tick at count zero wraps the count to all ones (0xFFFF for CNT_W = 16).
- R8: Every underflow sets `irq` on the next cycle. `irq` then stays high, even while counting continues, until it is acknowledged.
- R9: A write of any data to offset 3 clears `irq` on the next cycle.
- R10: When an acknowledge write and an underflow fall in the same cycle, `irq` stays high.
- R11: A write to the reload register while enabled also puts the written value into the count on the next cycle. The same write while disabled leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| tick_fast | input | 1 | Fast tick enable strobe |
| tick_slow | input | 1 | Slow tick enable strobe |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
The directed sequence first drives pulses on the unselected strobe and then on the selected one. This separates a correct tick select from a swapped or ORed one. It then runs full periods in both modes, so the reload path can be told apart from the wrap path and an off-by-one period can be seen. Acknowledges are issued once in an idle cycle and once in the same cycle as an underflow, which separates the two priority orders. A pseudo-random phase of mixed writes, mode changes and ticks on both strobes is then compared every cycle against a behavioural model. It catches ordering faults, such as a mode change while running or a reload write at the moment of underflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam logic [1:0] OFS_RELOAD = 2'd0;
   localparam logic [1:0] OFS_COUNT  = 2'd1;
   localparam logic [1:0] OFS_CTRL   = 2'd2;
   localparam logic [1:0] OFS_ACK    = 2'd3;

   localparam int BIT_EN   = 7;
   localparam int BIT_PER  = 6;
   localparam int BIT_FAST = 3;

   typedef struct packed {
      logic en;
      logic periodic;
      logic fast;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count,
   output tmr_ctrl_t         ctrl,
   output logic [CNT_W-1:0]  reload_q,
   output logic              en_start,
   output logic              reload_live,
   output logic              ack_wr,
   output logic [DATA_W-1:0] rdata
);
   logic wr_reload, wr_ctrl;
   logic [DATA_W-1:0] reload_ext, count_ext, ctrl_ext;
   logic unused_wdata;

   assign unused_wdata = ^wdata;
   assign wr_reload    = we && (addr == OFS_RELOAD);
   assign wr_ctrl      = we && (addr == OFS_CTRL);
   assign ack_wr       = we && (addr == OFS_ACK);
   assign en_start     = wr_ctrl && wdata[BIT_EN] && !ctrl.en;
   assign reload_live  = wr_reload && ctrl.en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         ctrl     <= '0;
      end else begin
         if (wr_reload) reload_q <= wdata[CNT_W-1:0];
         if (wr_ctrl) begin
            ctrl.en       <= wdata[BIT_EN];
            ctrl.periodic <= wdata[BIT_PER];
            ctrl.fast     <= wdata[BIT_FAST];
         end
      end
   end

   generate
      if (CNT_W == DATA_W) begin : g_full
         assign reload_ext = reload_q;
         assign count_ext  = count;
      end else begin : g_pad
         assign reload_ext = {{(DATA_W-CNT_W){1'b0}}, reload_q};
         assign count_ext  = {{(DATA_W-CNT_W){1'b0}}, count};
      end
   endgenerate

   always_comb begin
      ctrl_ext           = '0;
      ctrl_ext[BIT_EN]   = ctrl.en;
      ctrl_ext[BIT_PER]  = ctrl.periodic;
      ctrl_ext[BIT_FAST] = ctrl.fast;
   end

   always_comb begin
      unique case (addr)
         OFS_RELOAD: rdata = reload_ext;
         OFS_COUNT:  rdata = count_ext;
         OFS_CTRL:   rdata = ctrl_ext;
         default:    rdata = '0;
      endcase
   end

   assert_start_only_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_start |=> ctrl.en);
   assert_count_offset_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == OFS_COUNT) |=> $stable(reload_q) && $stable(ctrl));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             periodic,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload_q,
   input  logic             force_ld,
   input  logic [CNT_W-1:0] force_val,
   output logic [CNT_W-1:0] count,
   output logic             underflow
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic step;
   assign step      = en && tick && !force_ld;
   assign underflow = step && (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)          count <= '0;
      else if (force_ld)   count <= force_val;
      else if (underflow)  count <= periodic ? reload_q : ALL_ONES;
      else if (step)       count <= count - CNT_W'(1);
   end

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !force_ld && count == '0 && periodic) |=> count == $past(reload_q));
   assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !force_ld && count == '0 && !periodic) |=> (&count));
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !force_ld) |=> $stable(count));
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !force_ld && count != '0) |=> count == $past(count) - CNT_W'(1));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic underflow,
   input  logic ack,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)         irq <= 1'b0;
      else if (underflow) irq <= 1'b1;
      else if (ack)       irq <= 1'b0;
   end

   assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> irq);
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);
   assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !underflow) |=> !irq);
   assert_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && underflow) |=> irq);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_fast,
   input  logic              tick_slow,
   output logic              irq
);
   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold control bit 7");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
   endgenerate

   tmr_ctrl_t        ctrl;
   logic [CNT_W-1:0] reload_q, count, force_val;
   logic             en_start, reload_live, ack_wr, tick, underflow, force_ld;

   tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .count(count), .ctrl(ctrl), .reload_q(reload_q), .en_start(en_start),
      .reload_live(reload_live), .ack_wr(ack_wr), .rdata(bus_rdata)
   );

   assign tick      = ctrl.fast ? tick_fast : tick_slow;
   assign force_ld  = en_start || reload_live;
   assign force_val = en_start ? reload_q : bus_wdata[CNT_W-1:0];

   tmr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .periodic(ctrl.periodic), .tick(tick),
      .reload_q(reload_q), .force_ld(force_ld), .force_val(force_val),
      .count(count), .underflow(underflow)
   );

   tmr_irq u_irq (
      .clk(clk), .rst_n(rst_n), .underflow(underflow), .ack(ack_wr), .irq(irq)
   );

   assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_start |=> count == $past(reload_q));
   assert_live_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reload_live |=> count == $past(bus_wdata[CNT_W-1:0]));
   assert_tick_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.en && !force_ld && count != '0 &&
       !(ctrl.fast ? tick_fast : tick_slow)) |=> $stable(count));
endmodule

// File: tb/test_reload_timer.sv
`timescale 1ns/1ps
module test_reload_timer;
   localparam int CNT_W  = 16;
   localparam int DATA_W = 32;
   localparam int MASK   = 32'h0000FFFF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [1:0]        bus_addr = 2'd0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              tick_fast = 1'b0;
   logic              tick_slow = 1'b0;
   logic              irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   reload_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_reload_timer (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
      .tick_slow(tick_slow), .irq(irq)
   );

   // behavioural reference model
   int m_reload, m_cnt;
   bit m_en, m_per, m_fast, m_irq;

   function automatic int exp_rd(input logic [1:0] a);
      case (a)
         2'd0: return m_reload;
         2'd1: return m_cnt;
         2'd2: return (int'(m_en) << 7) | (int'(m_per) << 6) | (int'(m_fast) << 3);
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      bit tk, uf;
      int nc;
      if (!rst_n) begin
         m_reload = 0; m_cnt = 0; m_en = 0; m_per = 0; m_fast = 0; m_irq = 0;
      end else begin
         tk = m_fast ? tick_fast : tick_slow;
         uf = 0;
         nc = m_cnt;
         if (bus_we && bus_addr == 2'd2 && bus_wdata[7] && !m_en) nc = m_reload;
         else if (bus_we && bus_addr == 2'd0 && m_en) nc = int'(bus_wdata) & MASK;
         else if (m_en && tk) begin
            if (m_cnt == 0) begin
               uf = 1;
               nc = m_per ? m_reload : MASK;
            end else nc = m_cnt - 1;
         end
         if (bus_we && bus_addr == 2'd0) m_reload = int'(bus_wdata) & MASK;
         if (bus_we && bus_addr == 2'd2) begin
            m_en = bus_wdata[7]; m_per = bus_wdata[6]; m_fast = bus_wdata[3];
         end
         if (uf) m_irq = 1;
         else if (bus_we && bus_addr == 2'd3) m_irq = 0;
         m_cnt = nc;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq !== m_irq) begin
            fails++;
            $display("FAIL R8 model irq: actual %0b expected %0b", irq, m_irq);
         end
         checks++;
         if (bus_rdata !== exp_rd(bus_addr)) begin
            fails++;
            $display("FAIL R4 model read @%0d: actual %h expected %h",
                     bus_addr, bus_rdata, exp_rd(bus_addr));
         end
      end
   end

   task automatic cyc(input bit we, input logic [1:0] a, input int d,
                      input bit tf, input bit ts);
      @(negedge clk); #1;
      bus_we = we; bus_addr = a; bus_wdata = d; tick_fast = tf; tick_slow = ts;
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      cyc(1, a, d, 0, 0);
   endtask

   task automatic pulses(input int n, input bit fast);
      for (int i = 0; i < n; i++) cyc(0, 2'd1, 0, fast, !fast);
   endtask

   task automatic check_rd(input logic [1:0] a, input int exp, input string tag);
      cyc(0, a, 0, 0, 0);
      #2;
      checks++;
      if (bus_rdata !== exp) begin
         fails++;
         $display("FAIL %s read @%0d: actual %h expected %h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic check_irq(input bit exp, input string tag);
      cyc(0, 2'd1, 0, 0, 0);
      #2;
      checks++;
      if (irq !== exp) begin
         fails++;
         $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int unsigned seed;
      int op;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      check_rd(2'd0, 0, "R1");
      check_rd(2'd1, 0, "R1");
      check_rd(2'd2, 0, "R1");
      check_irq(0, "R1");

      wr(2'd2, 32'h48);
      wr(2'd0, 4);
      check_rd(2'd2, 32'h48, "R2");
      check_rd(2'd0, 4, "R2");
      check_rd(2'd1, 0, "R11");
      wr(2'd1, 32'h55);
      check_rd(2'd1, 0, "R2");
      wr(2'd2, 32'hFFFF_FF37);
      check_rd(2'd2, 0, "R2");
      wr(2'd2, 32'h48);
      wr(2'd2, 32'hC8);
      check_rd(2'd1, 4, "R3");
      pulses(3, 0);
      check_rd(2'd1, 4, "R5");
      pulses(1, 1);
      check_rd(2'd1, 3, "R4");
      pulses(3, 1);
      check_rd(2'd1, 0, "R4");
      check_irq(0, "R8");
      pulses(1, 1);
      check_rd(2'd1, 4, "R6");
      check_irq(1, "R8");
      pulses(5, 1);
      check_rd(2'd1, 4, "R6");
      check_irq(1, "R8");
      wr(2'd3, 32'h1234);
      check_irq(0, "R9");
      pulses(4, 1);
      cyc(1, 2'd3, 0, 1, 0);
      check_irq(1, "R10");
      check_rd(2'd1, 4, "R10");
      wr(2'd3, 0);
      wr(2'd2, 32'h88);
      check_rd(2'd1, 4, "R7");
      pulses(4, 1);
      check_irq(0, "R7");
      pulses(1, 1);
      check_rd(2'd1, 32'hFFFF, "R7");
      check_irq(1, "R8");
      wr(2'd2, 32'h80);
      pulses(2, 1);
      check_rd(2'd1, 32'hFFFF, "R5");
      pulses(1, 0);
      check_rd(2'd1, 32'hFFFE, "R5");
      wr(2'd0, 32'h10);
      check_rd(2'd1, 32'h10, "R11");
      wr(2'd2, 0);
      pulses(3, 1);
      pulses(3, 0);
      check_rd(2'd1, 32'h10, "R4");
      wr(2'd0, 32'h20);
      check_rd(2'd1, 32'h10, "R11");
      check_rd(2'd0, 32'h20, "R11");
      wr(2'd2, 32'hC8);
      check_rd(2'd1, 32'h20, "R3");

      seed = 32'h1F2E3D4C;
      for (int i = 0; i < 2000; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         op = int'((seed >> 16) % 16);
         case (op)
            0: wr(2'd0, int'((seed >> 8) & 7));
            1: wr(2'd2, int'(seed >> 4) & 32'hC8);
            2: wr(2'd3, int'(seed));
            3: wr(2'd1, int'(seed));
            default: cyc(0, 2'(seed >> 3), 0, seed[20], seed[21]);
         endcase
      end
      cyc(0, 2'd1, 0, 0, 0);
      @(negedge clk);
      #2;
      finish_run();
   end
endmodule